// File: doc/BRIEF.md
# HDMI Audio Sample Packet Assembler

This block gathers stereo audio samples into the four subpackets of an HDMI audio sample packet and keeps the packet's 24-bit header up to date as samples arrive. It needs no audio clock. An internal phase accumulator adds a fixed step to a running total on every pixel clock. When the total crosses a modulus, the block captures the current left and right sample words. With the default step of 4 and modulus of 3375, a 27 MHz pixel clock gives 32 kHz audio, which is one capture every 843.75 clocks on average.

Each capture fills the subpacket selected by a head pointer and sets that subpacket's sample-present flag in the header. If the capture falls on the first frame of the 192-frame channel-status cycle, the subpacket's block-start flag is also set. The flags build up until the data-island scheduler takes the packet. The packet side is a valid/ready pair. `pkt_valid` is high whenever at least one sample is waiting. A handshake (`pkt_valid` and `pkt_ready` high at the same clock edge) takes the packet: the header clears and the head pointer returns to subpacket 0. `pkt_ready` has no effect while `pkt_valid` is low.

The sample input has no back-pressure, because the audio rate is fixed by the accumulator. When four samples are already waiting, any further capture is dropped and a sticky overflow flag is raised. A scheduler that takes one packet per 858-pixel line never reaches that case.

Top module: `audio_pkt_asm`

## Requirements
- R1: While reset is asserted and at the first falling edge after it is released, `pkt_header` is 0, `pkt_valid` is 0 and `ovf_flag` is 0.
- R2: Number the rising edges from the first edge after reset is released, starting at 1. A capture happens at edge n exactly when floor(4n/3375) > floor(4(n-1)/3375). The first capture is therefore at edge 844. Its results are visible after that edge and not before it.
- R3: A captured sample is written to the subpacket at the head pointer, and the pointer then advances through 0..3. Each subpacket word is laid out as follows:
  - bits [23:0]: the left sample, left-justified (the sample shifted up by 24 - SAMPLE_W).
  - bits [47:24]: the right sample, left-justified.
  - bits 48..51: the left channel's validity (0), user (0), channel-status and parity bits.
  - bits 52..55: the same four bits for the right channel.
  - A subpacket word keeps its value until it is overwritten.
- R4: While a packet is pending, header bit 1 is set, so the low byte reads 0x02. A capture into subpacket n sets header bit 8+n. Flags that are already set stay set until the packet is taken.
- R5: A capture into subpacket n made while the channel-status index is 0 also sets header bit 20+n.
- R6: The channel-status index starts at 0, advances by one on each accepted capture and wraps from 191 to 0. The channel-status bit of both channels is 1 exactly when the index is in 24..27 and bit (index-24) of RATE_CODE is 1. With the default RATE_CODE of 4'b0011, that is indices 24 and 25.
- R7: Each channel's parity bit is the XOR of its 24 sample bits and its validity, user and channel-status bits, which gives even parity.
- R8: A handshake at an edge with no capture at the same edge clears `pkt_header` to 0 and `pkt_valid` to 0 after that edge.
- R9: When a handshake and a capture happen at the same edge, the new sample goes to subpacket 0 of a fresh packet, and its flags are the only ones set in the header.
- R10: A capture that arrives with four samples pending, and no handshake at the same edge, is dropped. The dropped capture leaves the header, the subpackets and the channel-status index unchanged, and sets `ovf_flag`. Only reset clears `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_left | input | SAMPLE_W | Left sample word, read at a capture edge |
| smp_right | input | SAMPLE_W | Right sample word, read at a capture edge |
| pkt_ready | input | 1 | Scheduler accepts the pending packet |
| pkt_valid | output | 1 | At least one sample is pending |
| pkt_header | output | 24 | Packet header: type, sample-present flags, block-start flags |
| sub0 | output | 56 | Subpacket 0 payload |
| sub1 | output | 56 | Subpacket 1 payload |
| sub2 | output | 56 | Subpacket 2 payload |
| sub3 | output | 56 | Subpacket 3 payload |
| ovf_flag | output | 1 | Sticky overflow: a capture was dropped |

## Verification
Every result of this block becomes visible one edge after the edge that causes it. A capture changes the header and the subpackets right after the capture edge, and a handshake clears the header right after the edge it occurs on. The bench computes each capture edge from the accumulator formula in R2. It checks that nothing has changed at the falling edge just before the capture edge, and that the expected values are present at the falling edge just after it. The bench drives handshakes and samples outputs only at falling edges, so a coinciding handshake lands exactly on a predicted capture edge.

// File: rtl/apa_pkg.sv
package apa_pkg;
  localparam int SUB_N    = 4;
  localparam int SUB_W    = 56;
  localparam int HDR_W    = 24;
  localparam int CH_W     = 24;
  localparam int PRES_LSB = 8;
  localparam int BLK_LSB  = 20;
  localparam logic [HDR_W-1:0] TYPE_BITS = 24'h000002;

  typedef logic [SUB_W-1:0] subpkt_t;

  // Validity and user bits are always zero; parity makes each channel even.
  function automatic subpkt_t pack_subpkt(input logic [CH_W-1:0] l,
                                          input logic [CH_W-1:0] r,
                                          input logic cs);
    logic pl, pr;
    pl = ^{l, cs};
    pr = ^{r, cs};
    return {pr, cs, 1'b0, 1'b0, pl, cs, 1'b0, 1'b0, r, l};
  endfunction
endpackage

// File: rtl/apa_rate_gen.sv
module apa_rate_gen #(
  parameter int STEP = 4,
  parameter int MOD  = 3375
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int AW = $clog2(MOD + STEP + 1);

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  assign sum  = acc + AW'(STEP);
  assign tick = (sum >= AW'(MOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (tick) acc <= sum - AW'(MOD);
    else           acc <= sum;
  end
endmodule

// File: rtl/apa_chstat.sv
module apa_chstat #(
  parameter int         CS_LEN    = 192,
  parameter logic [3:0] RATE_CODE = 4'b0011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic cs_bit,
  output logic blk_start
);
  localparam int IW       = $clog2(CS_LEN);
  localparam int RATE_POS = 24;

  function automatic logic [CS_LEN-1:0] build_vec();
    logic [CS_LEN-1:0] v;
    v = '0;
    for (int k = 0; k < 4; k++) begin
      if (RATE_POS + k < CS_LEN) v[RATE_POS+k] = RATE_CODE[k];
    end
    return v;
  endfunction

  localparam logic [CS_LEN-1:0] CS_VEC = build_vec();

  logic [IW-1:0] idx;

  assign cs_bit    = CS_VEC[idx];
  assign blk_start = (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else if (adv) begin
      if (idx == IW'(CS_LEN - 1)) idx <= '0;
      else                        idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/apa_slot_bank.sv
module apa_slot_bank
  import apa_pkg::*;
#(
  parameter int N = SUB_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    we,
  input  subpkt_t         din,
  output subpkt_t         q [N]
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[g] <= '0;
      else if (we[g]) q[g] <= din;
    end
  end
endmodule

// File: rtl/audio_pkt_asm.sv
module audio_pkt_asm
  import apa_pkg::*;
#(
  parameter int         SAMPLE_W  = 16,
  parameter int         ACC_STEP  = 4,
  parameter int         ACC_MOD   = 3375,
  parameter int         CS_LEN    = 192,
  parameter logic [3:0] RATE_CODE = 4'b0011
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                pkt_ready,
  output logic                pkt_valid,
  output logic [HDR_W-1:0]    pkt_header,
  output logic [SUB_W-1:0]    sub0,
  output logic [SUB_W-1:0]    sub1,
  output logic [SUB_W-1:0]    sub2,
  output logic [SUB_W-1:0]    sub3,
  output logic                ovf_flag
);
  localparam int CW    = $clog2(SUB_N + 1);
  localparam int SW    = $clog2(SUB_N);
  localparam int SHIFT = CH_W - SAMPLE_W;

  logic            tick;
  logic            cs_bit;
  logic            blk_start;
  logic            take;
  logic            accept;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   cnt_base;
  logic [SW-1:0]   slot;
  logic [SUB_N-1:0] we;
  logic [HDR_W-1:0] hdr;
  logic [HDR_W-1:0] hdr_base;
  logic [HDR_W-1:0] hdr_add;
  logic [CH_W-1:0]  l24, r24;
  subpkt_t          din;
  subpkt_t          q [SUB_N];

  apa_rate_gen #(.STEP(ACC_STEP), .MOD(ACC_MOD)) u_rate (
    .clk (clk),
    .rst_n (rst_n),
    .tick (tick)
  );

  apa_chstat #(.CS_LEN(CS_LEN), .RATE_CODE(RATE_CODE)) u_cs (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (accept),
    .cs_bit    (cs_bit),
    .blk_start (blk_start)
  );

  // Packet side handshake and slot selection
  assign take     = pkt_valid & pkt_ready;
  assign cnt_base = take ? '0 : cnt;
  assign accept   = tick & (cnt_base < CW'(SUB_N));
  assign slot     = cnt_base[SW-1:0];
  assign we       = accept ? (SUB_N'(1) << slot) : '0;

  assign l24 = CH_W'(smp_left)  << SHIFT;
  assign r24 = CH_W'(smp_right) << SHIFT;
  assign din = pack_subpkt(l24, r24, cs_bit);

  apa_slot_bank #(.N(SUB_N)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (we),
    .din   (din),
    .q     (q)
  );

  // Header flags accumulate at the moving slot
  assign hdr_base = take ? '0 : hdr;
  always_comb begin
    hdr_add = '0;
    if (accept) begin
      hdr_add = TYPE_BITS | (HDR_W'(1) << (PRES_LSB + int'(slot)));
      if (blk_start) hdr_add = hdr_add | (HDR_W'(1) << (BLK_LSB + int'(slot)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr      <= '0;
      cnt      <= '0;
      ovf_flag <= 1'b0;
    end else begin
      hdr <= hdr_base | hdr_add;
      cnt <= cnt_base + CW'(accept);
      if (tick && !accept) ovf_flag <= 1'b1;
    end
  end

  assign pkt_valid  = (cnt != '0);
  assign pkt_header = hdr;
  assign sub0 = q[0];
  assign sub1 = q[1];
  assign sub2 = q[2];
  assign sub3 = q[3];
endmodule

// File: rtl/apa_chk.sv
module apa_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        pkt_ready,
  input logic        pkt_valid,
  input logic [23:0] pkt_header,
  input logic        ovf_flag
);
  // R4
  valid_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid == pkt_header[1]);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && !tick) |=> (pkt_header == 24'h0));

  // R9
  merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready && tick) |=> (pkt_header[11:8] == 4'b0001));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  // R10
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pkt_header[11:8] == 4'hF && !pkt_ready) |=> ($stable(pkt_header) && ovf_flag));

  // R4
  accum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pkt_valid && pkt_ready) |=> ((pkt_header & $past(pkt_header)) == $past(pkt_header)));

  // R3
  fill_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_header[11:8] == 4'h0) || (pkt_header[11:8] == 4'h1) || (pkt_header[11:8] == 4'h3) ||
    (pkt_header[11:8] == 4'h7) || (pkt_header[11:8] == 4'hF));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind audio_pkt_asm apa_chk u_apa_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .pkt_ready  (pkt_ready),
  .pkt_valid  (pkt_valid),
  .pkt_header (pkt_header),
  .ovf_flag   (ovf_flag)
);

// File: tb/tb_audio_pkt_asm.sv
module tb_audio_pkt_asm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] smp_left = '0;
  logic [15:0] smp_right = '0;
  logic        pkt_ready = 1'b0;
  logic        pkt_valid;
  logic [23:0] pkt_header;
  logic [55:0] sub0, sub1, sub2, sub3;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int bidx = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  audio_pkt_asm dut (
    .clk (clk), .rst_n (rst_n), .smp_left (smp_left), .smp_right (smp_right),
    .pkt_ready (pkt_ready), .pkt_valid (pkt_valid), .pkt_header (pkt_header),
    .sub0 (sub0), .sub1 (sub1), .sub2 (sub2), .sub3 (sub3), .ovf_flag (ovf_flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_cap(int n);
    return ((4 * n) / 3375) != ((4 * (n - 1)) / 3375);
  endfunction

  function automatic int next_cap(int c);
    int n = c + 1;
    while (!is_cap(n)) n++;
    return n;
  endfunction

  function automatic logic exp_c(int idx);
    return (idx == 24) || (idx == 25);
  endfunction

  function automatic logic [55:0] exp_sp(logic [15:0] l, logic [15:0] r, int idx);
    logic [23:0] l24 = {l, 8'h00};
    logic [23:0] r24 = {r, 8'h00};
    logic c = exp_c(idx);
    logic pl = ^{l24, c};
    logic pr = ^{r24, c};
    return {pr, c, 2'b00, pl, c, 2'b00, r24, l24};
  endfunction

  // Advance to the falling edge just before the next capture edge
  task automatic wait_before_cap();
    int nc = next_cap(cyc);
    while (cyc < nc - 1) @(negedge clk);
  endtask

  task automatic capture(input logic [15:0] l, input logic [15:0] r);
    smp_left = l;
    smp_right = r;
    wait_before_cap();
    @(negedge clk);
  endtask

  task automatic send();
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 header", 64'(pkt_header), 64'h0);
    chk("R1 valid", 64'(pkt_valid), 64'h0);
    chk("R1 ovf", 64'(ovf_flag), 64'h0);
  endtask

  task automatic t_first();
    smp_left = 16'hA001;
    smp_right = 16'h5001;
    wait_before_cap();
    chk("R2 capture edge 844", 64'(cyc + 1), 64'd844);
    chk("R2 nothing before capture", 64'(pkt_valid), 64'h0);
    @(negedge clk);
    chk("R4 R5 first header", 64'(pkt_header), 64'h100102);
    chk("R4 valid", 64'(pkt_valid), 64'h1);
    chk("R3 R6 R7 sub0", 64'(sub0), 64'(exp_sp(16'hA001, 16'h5001, 0)));
    bidx = 1;
  endtask

  task automatic t_send();
    send();
    chk("R8 header cleared", 64'(pkt_header), 64'h0);
    chk("R8 valid low", 64'(pkt_valid), 64'h0);
    chk("R3 payload kept", 64'(sub0), 64'(exp_sp(16'hA001, 16'h5001, 0)));
  endtask

  task automatic t_accum();
    capture(16'h1234, 16'hFEDC);
    chk("R4 one flag", 64'(pkt_header), 64'h000102);
    chk("R3 sub0", 64'(sub0), 64'(exp_sp(16'h1234, 16'hFEDC, 1)));
    capture(16'h8001, 16'h0003);
    chk("R4 flags accumulate", 64'(pkt_header), 64'h000302);
    chk("R3 R7 sub1", 64'(sub1), 64'(exp_sp(16'h8001, 16'h0003, 2)));
    bidx = 3;
  endtask

  task automatic t_overflow();
    capture(16'h0F0F, 16'hF0F0);
    chk("R4 three flags", 64'(pkt_header), 64'h000702);
    capture(16'h7777, 16'h1111);
    chk("R4 four flags", 64'(pkt_header), 64'h000F02);
    chk("R3 sub3", 64'(sub3), 64'(exp_sp(16'h7777, 16'h1111, 4)));
    chk("R10 no ovf yet", 64'(ovf_flag), 64'h0);
    capture(16'hDEAD, 16'hBEEF);
    chk("R10 header unchanged", 64'(pkt_header), 64'h000F02);
    chk("R10 ovf set", 64'(ovf_flag), 64'h1);
    chk("R10 sub0 untouched", 64'(sub0), 64'(exp_sp(16'h1234, 16'hFEDC, 1)));
    chk("R10 sub3 untouched", 64'(sub3), 64'(exp_sp(16'h7777, 16'h1111, 4)));
    bidx = 5;
    send();
    chk("R10 ovf sticky", 64'(ovf_flag), 64'h1);
  endtask

  task automatic t_coincide();
    capture(16'h2222, 16'h3333);
    chk("R9 pending one", 64'(pkt_header), 64'h000102);
    smp_left = 16'h4444;
    smp_right = 16'h5555;
    wait_before_cap();
    pkt_ready = 1'b1;
    @(negedge clk);
    pkt_ready = 1'b0;
    chk("R9 fresh header", 64'(pkt_header), 64'h000102);
    chk("R9 valid", 64'(pkt_valid), 64'h1);
    chk("R9 sub0 new sample", 64'(sub0), 64'(exp_sp(16'h4444, 16'h5555, 6)));
    bidx = 7;
    send();
  endtask

  task automatic t_long();
    bit wrapped = 0;
    while (!(wrapped && bidx == 3)) begin
      logic [15:0] l = 16'h9000 ^ 16'(bidx * 37);
      logic [15:0] r = 16'h0100 + 16'(bidx);
      capture(l, r);
      chk(bidx == 0 ? "R5 R6 wrap block start" : "R5 R6 header",
          64'(pkt_header), bidx == 0 ? 64'h100102 : 64'h000102);
      chk("R6 R7 status and parity", 64'(sub0), 64'(exp_sp(l, r, bidx)));
      bidx = (bidx + 1) % 192;
      if (bidx == 0) wrapped = 1;
      send();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_send();
    t_accum();
    t_overflow();
    t_coincide();
    t_long();
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule